// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits on the host side of a byte-wide asynchronous static RAM. Its front end is a plain synchronous request port: a valid strobe, a write flag, a 13-bit byte address and an 8-bit write value. It turns each accepted request into a timed sequence of active-low chip-enable, write-enable and output-enable strobes on the memory pins, and it drives the shared three-state data bus during writes. The controller takes one request at a time. When the access is over it pulses `done` for one cycle. For reads, the captured byte is on `rd_data` in that same cycle.

The memory's limits are set as nanosecond parameters, and the system clock period is set in picoseconds. Each limit is rounded up to whole cycles, so the number of cycles spent in each strobe phase comes from the parameters. Writes are timed by the write-enable pulse. Reads hold chip enable and output enable low until the slowest of the address, chip-enable and output-enable access paths has elapsed, then capture one cycle later. After any read, the output-off interval must pass before the controller drives the bus again.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, all three strobes are high (inactive), the data bus is not driven, `req_ready` is 1 and `done` is 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1. `req_ready` drops on the next cycle and stays low until the access has fully completed. A request presented while `req_ready` is 0 has no effect on the memory.
- R3: In a write, the address and chip enable (low) are presented at least one cycle before write enable falls. The address stays unchanged while write enable is low and at the cycle in which it rises.
- R4: Write enable stays low for at least 50 ns. The address is valid at least 60 ns before write enable rises, and the write data is valid at least 30 ns before it rises.
- R5: Write data stays on the bus for at least 5 ns after write enable rises, and then the bus is released.
- R6: From the point where a write's address is presented, the address does not change again for at least 70 ns.
- R7: Output enable is high for the whole of any write. The controller starts driving the bus only after output enable has been high for at least 25 ns.
- R8: A read holds chip enable and output enable low with write enable high. It captures the bus on the first clock edge after the largest of the three 70 ns access times has elapsed, which is 75 ns after the strobes assert at a 5 ns clock.
- R9: `done` is a single-cycle pulse at the end of every access. On a read, `rd_data` holds the captured byte while `done` is 1.
- R10: Every nanosecond limit is converted to cycles as ceil(ns*1000/CLK_PS), with a minimum of one cycle for any non-zero limit. At the default 5000 ps clock, the write-enable low pulse is exactly 11 cycles (55 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address of the request |
| req_wdata | input | 8 | Byte to store on a write |
| req_ready | output | 1 | Controller idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| sram_addr | output | 13 | Address pins to the memory |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq | inout | 8 | Shared three-state data bus |

## Verification
The main function is tested in several ways. Write-then-read pairs use complementary and alternating byte patterns at the lowest and highest addresses, which separates real storage from stuck or swapped bits. Back-to-back read-then-write sequences test the bus turnaround. Consecutive writes to different addresses show whether the write cycle time is respected before the address moves on. The memory model returns the inverted byte until its access time has passed, so a capture made too early reads the wrong value rather than passing by chance. A request raised while the controller is busy, followed by a read of the same address, shows whether that request was dropped.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WSET = 3'd1,
    ST_WPUL = 3'd2,
    ST_WHLD = 3'd3,
    ST_WREC = 3'd4,
    ST_RACC = 3'd5,
    ST_ROFF = 3'd6
  } seq_state_e;

  // Round a nanosecond limit up to whole clock cycles.
  function automatic int ns_to_cyc(input int lim_ns, input int clk_ps);
    int c;
    if (lim_ns <= 0) return 0;
    c = (lim_ns * 1000 + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
`timescale 1ns/1ps
module sram_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int CW     = 4,
  parameter int SET_L  = 0,
  parameter int PUL_L  = 10,
  parameter int HLD_L  = 0,
  parameter int REC_L  = 0,
  parameter int RACC_L = 14,
  parameter int ROFF_L = 4,
  parameter bit HAS_REC = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_zero,
  output seq_state_e    state_q,
  output seq_state_e    state_d,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept,
  output logic          cap_en,
  output logic          done_d,
  output logic          ready
);

  seq_state_e st_q;
  seq_state_e st_d;

  assign ready  = (st_q == ST_IDLE);
  assign accept = ready && req_valid;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_en   = 1'b0;
    done_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          if (req_write) begin
            st_d    = ST_WSET;
            tmr_val = CW'(SET_L);
          end else begin
            st_d    = ST_RACC;
            tmr_val = CW'(RACC_L);
          end
        end
      end
      ST_WSET: begin
        if (tmr_zero) begin
          st_d     = ST_WPUL;
          tmr_load = 1'b1;
          tmr_val  = CW'(PUL_L);
        end
      end
      ST_WPUL: begin
        if (tmr_zero) begin
          st_d     = ST_WHLD;
          tmr_load = 1'b1;
          tmr_val  = CW'(HLD_L);
        end
      end
      ST_WHLD: begin
        if (tmr_zero) begin
          if (HAS_REC) begin
            st_d     = ST_WREC;
            tmr_load = 1'b1;
            tmr_val  = CW'(REC_L);
          end else begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
      end
      ST_WREC: begin
        if (tmr_zero) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      ST_RACC: begin
        if (tmr_zero) begin
          st_d     = ST_ROFF;
          tmr_load = 1'b1;
          tmr_val  = CW'(ROFF_L);
          cap_en   = 1'b1;
          done_d   = 1'b1;
        end
      end
      ST_ROFF: begin
        if (tmr_zero) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign state_q = st_q;
  assign state_d = st_d;

endmodule

// File: rtl/sram_seq_dpath.sv
`timescale 1ns/1ps
module sram_seq_dpath
  import sram_seq_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    state_d,
  input  logic          accept,
  input  logic          cap_en,
  input  logic          done_d,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          drv_o,
  output logic          ce_n_o,
  output logic          we_n_o,
  output logic          oe_n_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          done_q;
  logic          ce_n_q, we_n_q, oe_n_q, drv_q;
  logic          ce_n_d, we_n_d, oe_n_d, drv_d;

  // Strobes are registered from the next state so pins change on clean edges.
  always_comb begin
    ce_n_d = 1'b1;
    we_n_d = 1'b1;
    oe_n_d = 1'b1;
    drv_d  = 1'b0;
    unique case (state_d)
      ST_WSET: begin ce_n_d = 1'b0; drv_d = 1'b1; end
      ST_WPUL: begin ce_n_d = 1'b0; we_n_d = 1'b0; drv_d = 1'b1; end
      ST_WHLD: begin ce_n_d = 1'b0; drv_d = 1'b1; end
      ST_RACC: begin ce_n_d = 1'b0; oe_n_d = 1'b0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_q <= 1'b1;
      we_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      drv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ce_n_q <= ce_n_d;
      we_n_q <= we_n_d;
      oe_n_q <= oe_n_d;
      drv_q  <= drv_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= bus_in;
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign drv_o   = drv_q;
  assign ce_n_o  = ce_n_q;
  assign we_n_o  = we_n_q;
  assign oe_n_o  = oe_n_q;
  assign rdata_o = rdata_q;
  assign done_o  = done_q;

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int AW         = 13,
  parameter int DW         = 8,
  parameter int CLK_PS     = 5000,
  parameter int T_AS_NS    = 0,
  parameter int T_WP_NS    = 50,
  parameter int T_WC_NS    = 70,
  parameter int T_DS_NS    = 30,
  parameter int T_DH_NS    = 5,
  parameter int T_AW_NS    = 60,
  parameter int T_OFF_NS   = 25,
  parameter int T_ACC_A_NS = 70,
  parameter int T_ACC_C_NS = 70,
  parameter int T_ACC_O_NS = 70
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  inout  wire  [DW-1:0] sram_dq
);

  // Cycle counts per phase (R10)
  localparam int C_AS   = ns_to_cyc(T_AS_NS, CLK_PS);
  localparam int C_WP   = ns_to_cyc(T_WP_NS, CLK_PS);
  localparam int C_WC   = ns_to_cyc(T_WC_NS, CLK_PS);
  localparam int C_DS   = ns_to_cyc(T_DS_NS, CLK_PS);
  localparam int C_DH   = ns_to_cyc(T_DH_NS, CLK_PS);
  localparam int C_AW   = ns_to_cyc(T_AW_NS, CLK_PS);
  localparam int C_OFF  = ns_to_cyc(T_OFF_NS, CLK_PS);
  localparam int C_ACC  = ns_to_cyc(imax(T_ACC_A_NS, imax(T_ACC_C_NS, T_ACC_O_NS)), CLK_PS);

  localparam int SET_N  = imax(1, C_AS);
  localparam int PUL_N  = imax(imax(1, C_WP), imax(C_AW - SET_N, C_DS - SET_N));
  localparam int HLD_N  = imax(1, C_DH);
  localparam int REC_N  = imax(0, C_WC - SET_N - PUL_N - HLD_N);
  localparam int RACC_N = imax(1, C_ACC) + 1;
  localparam int ROFF_N = imax(1, C_OFF);
  localparam bit HAS_REC = (REC_N > 0);

  localparam int MAXL = imax(imax(PUL_N, RACC_N), imax(imax(SET_N, HLD_N), imax(REC_N, ROFF_N)));
  localparam int CW   = $clog2(MAXL + 1);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  seq_state_e    state_q;
  seq_state_e    state_d;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          accept;
  logic          cap_en;
  logic          done_d;
  logic          dq_drv;
  logic [DW-1:0] wdata_q;

  sram_seq_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_seq_fsm #(
    .CW      (CW),
    .SET_L   (SET_N - 1),
    .PUL_L   (PUL_N - 1),
    .HLD_L   (HLD_N - 1),
    .REC_L   (imax(REC_N - 1, 0)),
    .RACC_L  (RACC_N - 1),
    .ROFF_L  (ROFF_N - 1),
    .HAS_REC (HAS_REC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req_valid (req_valid),
    .req_write (req_write),
    .tmr_zero  (tmr_zero),
    .state_q   (state_q),
    .state_d   (state_d),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (accept),
    .cap_en    (cap_en),
    .done_d    (done_d),
    .ready     (req_ready)
  );

  sram_seq_dpath #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .state_d   (state_d),
    .accept    (accept),
    .cap_en    (cap_en),
    .done_d    (done_d),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .bus_in    (sram_dq),
    .addr_o    (sram_addr),
    .wdata_o   (wdata_q),
    .drv_o     (dq_drv),
    .ce_n_o    (sram_ce_n),
    .we_n_o    (sram_we_n),
    .oe_n_o    (sram_oe_n),
    .rdata_o   (rd_data),
    .done_o    (done)
  );

  // Per-bit three-state drivers
  for (genvar b = 0; b < DW; b++) begin : g_dq
    assign sram_dq[b] = dq_drv ? wdata_q[b] : 1'bz;
  end

endmodule

// File: rtl/sram_seq_chk.sv
`timescale 1ns/1ps
module sram_seq_chk #(
  parameter int AW      = 13,
  parameter int WE_CYC  = 11,
  parameter int OFF_CYC = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          sram_ce_n,
  input logic          sram_we_n,
  input logic          sram_oe_n,
  input logic [AW-1:0] sram_addr,
  input logic          drv
);

  logic [15:0] we_cnt;
  logic [7:0]  oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_cnt    <= '0;
      oe_hi_cnt <= 8'(OFF_CYC);
    end else begin
      we_cnt    <= sram_we_n ? 16'd0 : we_cnt + 16'd1;
      oe_hi_cnt <= !sram_oe_n ? 8'd0 : ((oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1);
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !drv));

  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_we_with_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);

  p_ce_before_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> $past(!sram_ce_n));

  p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n || $rose(sram_we_n)) |-> $stable(sram_addr));

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_cnt >= 16'(WE_CYC)));

  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> drv);

  p_oe_off_in_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> sram_oe_n);

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv) |-> (oe_hi_cnt >= 8'(OFF_CYC)));

  p_read_strobes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (sram_we_n && !sram_ce_n && !drv));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind sram_seq_ctrl sram_seq_chk #(
  .AW      (AW),
  .WE_CYC  (PUL_N),
  .OFF_CYC (ROFF_N)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .sram_ce_n (sram_ce_n),
  .sram_we_n (sram_we_n),
  .sram_oe_n (sram_oe_n),
  .sram_addr (sram_addr),
  .drv       (dq_drv)
);

// File: tb/sim_sram_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sram_seq_ctrl;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [12:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, done;
  logic [7:0]  rd_data;
  logic [12:0] sram_addr;
  logic        sram_ce_n, sram_we_n, sram_oe_n;
  wire  [7:0]  dq;

  int n_chk = 0;
  int n_fail = 0;

  sram_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rd_data(rd_data), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_dq(dq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mem [int];
  logic [7:0] mdrv;
  logic       men;
  logic       mem_tick = 1'b0;
  logic       rd_ok = 1'b0;
  realtime    t_chg = 0;
  assign dq = men ? mdrv : 8'bz;

  always @(sram_addr or sram_ce_n or sram_oe_n) t_chg = $realtime;
  always #1 rd_ok = (($realtime - t_chg) >= 70.0);

  always @(sram_addr or sram_ce_n or sram_oe_n or sram_we_n or rd_ok or mem_tick) begin
    logic [7:0] mv;
    mv   = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
    men  = !sram_ce_n && !sram_oe_n && sram_we_n;
    mdrv = rd_ok ? mv : ~mv;
  end

  // ---------------- pin timing monitor ----------------
  realtime t_addr = -1000, t_wf = -1000, t_wr = -1000, t_dq = -1000;
  realtime t_oe_rise = -1000, t_oe_fall = -1000;
  bit      wr_open = 0;

  always @(posedge sram_oe_n) t_oe_rise = $realtime;
  always @(negedge sram_oe_n) t_oe_fall = $realtime;
  always @(dq) begin
    if (rst_n && sram_we_n && (($realtime - t_wr) < 5.0))
      chk("R5 data held after WE rise", 0, int'($realtime - t_wr), 5);
    t_dq = $realtime;
  end

  always @(sram_addr) begin
    if (rst_n) begin
      if (!sram_we_n) chk("R3 address moved while WE low", 0, 1, 0);
      if (wr_open)
        chk("R6 write cycle time (ns)", ($realtime - t_addr) >= 70.0, int'($realtime - t_addr), 70);
    end
    t_addr  = $realtime;
    wr_open = 0;
  end

  always @(negedge sram_we_n) begin
    if (rst_n) begin
      t_wf = $realtime;
      wr_open = 1;
      chk("R3 CE low at WE fall", !sram_ce_n, sram_ce_n, 0);
      chk("R7 OE high at WE fall", sram_oe_n, sram_oe_n, 1);
      chk("R7 OE off time before write (ns)", ($realtime - t_oe_rise) >= 25.0,
          int'($realtime - t_oe_rise), 25);
    end
  end

  always @(posedge sram_we_n) begin
    if (rst_n) begin
      t_wr = $realtime;
      chk("R4 WE low width (ns)", (t_wr - t_wf) >= 50.0, int'(t_wr - t_wf), 50);
      chk("R10 WE pulse rounded to 11 cycles (ns)", (t_wr - t_wf) == 55.0, int'(t_wr - t_wf), 55);
      chk("R4 address to WE high (ns)", (t_wr - t_addr) >= 60.0, int'(t_wr - t_addr), 60);
      chk("R4 data to WE high (ns)", (t_wr - t_dq) >= 30.0, int'(t_wr - t_dq), 30);
      if (!sram_ce_n) begin
        mem[int'(sram_addr)] = dq;
        mem_tick = ~mem_tick;
      end
    end
  end

  // ---------------- scoreboard ----------------
  logic [7:0] exp_mem [int];
  bit         q_rd [$];
  logic [7:0] q_d  [$];
  bit         done_prev = 0;

  task automatic issue(input bit wr, input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) begin
      exp_mem[int'(a)] = d;
      q_rd.push_back(1'b0); q_d.push_back(8'h00);
    end else begin
      q_rd.push_back(1'b1);
      q_d.push_back(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        chk("R9 done lasts one cycle", !done_prev, done_prev, 0);
        if (q_rd.size() == 0) begin
          chk("R9 unexpected done", 0, 1, 0);
        end else begin
          bit rd; logic [7:0] e;
          rd = q_rd.pop_front();
          e  = q_d.pop_front();
          if (rd) begin
            chk("R9 read data", rd_data == e, rd_data, e);
            chk("R8 capture after access (ns)", ($realtime - 2.5 - t_oe_fall) >= 75.0,
                int'($realtime - 2.5 - t_oe_fall), 75);
          end
        end
      end
      done_prev = done;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    #1000000;
    chk("watchdog", 0, 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 strobes idle", sram_ce_n && sram_we_n && sram_oe_n, {sram_ce_n, sram_we_n, sram_oe_n}, 7);
    chk("R1 ready after reset", req_ready, req_ready, 1);
    chk("R1 done low after reset", !done, done, 0);

    // boundary addresses, complementary patterns
    issue(1'b1, 13'h0000, 8'h5A);
    issue(1'b0, 13'h0000, 8'h00);
    issue(1'b1, 13'h1FFF, 8'hA5);
    issue(1'b0, 13'h1FFF, 8'h00);
    issue(1'b0, 13'h0777, 8'h00);          // never written
    // read immediately followed by write (turnaround, R7)
    issue(1'b1, 13'h1FFF, 8'hFF);
    issue(1'b0, 13'h0000, 8'h00);
    issue(1'b1, 13'h0001, 8'h00);
    // sweep of distinct addresses and patterns
    for (int i = 0; i < 8; i++)
      issue(1'b1, 13'((i * 13'h123) & 13'h1FFF), {4'(i), ~4'(i)});
    for (int i = 0; i < 8; i++)
      issue(1'b0, 13'((i * 13'h123) & 13'h1FFF), 8'h00);
    issue(1'b0, 13'h1FFF, 8'h00);
    issue(1'b0, 13'h0001, 8'h00);

    // R2: request while busy is dropped
    issue(1'b1, 13'h0010, 8'h11);
    chk("R2 ready low while busy", !req_ready, req_ready, 0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0010; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 1'b0;
    issue(1'b0, 13'h0010, 8'h00);          // expects 8'h11

    repeat (60) @(negedge clk);
    chk("R2 all accesses completed", q_rd.size() == 0, q_rd.size(), 0);
    chk("R2 idle at end", req_ready, req_ready, 1);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule